// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, a second operand held in the buffer register, and a 4-bit operation code from the control sequencer. It returns a 16-bit result together with a sign flag and a zero flag.

The operations are:

- add and subtract;
- bitwise AND, OR and invert;
- one-bit logical shifts of the accumulator in either direction;
- a multiply that keeps only the low product bits;
- an unsigned integer divide.

Unassigned codes hand the accumulator back unchanged, so the sequencer can use them as a no-operation. The result and flags are captured in an output register. They appear one clock after the operands and code are presented. The surrounding datapath writes that registered value back into the accumulator.

All operands are treated as unsigned 16-bit words. The only exception is the sign flag, which just reports the top bit of the result.

Top module: `acc_alu`

## Requirements
- R1: Code 0001 gives (accumulator + operand) modulo 2^16.
- R2: Code 0010 gives (accumulator - operand) in two's complement, wrapping modulo 2^16.
- R3: Code 0011 gives the bitwise AND of accumulator and operand. Code 0100 gives their bitwise OR.
- R4: Code 0101 gives the bitwise inverse of the operand. The accumulator value has no effect on this result.
- R5: Code 0110 shifts the accumulator right by one bit. A zero enters bit 15 and bit 0 is lost.
- R6: Code 0111 shifts the accumulator left by one bit. A zero enters bit 0 and bit 15 is lost.
- R7: Code 1000 gives the low 8 bits of accumulator times operand in result bits 7..0. Result bits 15..8 are zero.
- R8: Code 1001 with a non-zero operand gives the unsigned quotient of accumulator divided by operand, rounded down. The remainder is dropped.
- R9: Code 1001 with a zero operand gives 16'hFFFF.
- R10: Codes 0000 and 1010 through 1111 return the accumulator value unchanged.
- R11: The sign flag equals result bit 15. The zero flag is 1 exactly when all 16 result bits are 0.
- R12: Result and flags are registered. They reflect the inputs present at the previous rising clock edge. A synchronous active-high reset sets result to 0, sign to 0 and zero to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code from the control sequencer |
| acc_i | input | 16 | Accumulator operand |
| opnd_i | input | 16 | Buffer-register operand |
| result_o | output | 16 | Registered operation result |
| sign_o | output | 1 | Registered copy of result bit 15 |
| zero_o | output | 1 | Registered flag, 1 when the result is all zeros |

## Verification
Directed vectors cover the wrap points and the places where a mistake in one operation would look like a correct answer from another:

- add across FFFF and 7FFF;
- subtract below zero and to exactly zero;
- shifts of patterns with both end bits set, which expose a rotate or an arithmetic shift;
- products whose true value exceeds 8 bits;
- divides with a remainder and by zero.

Invert is applied with differing accumulator values, which shows whether the wrong operand is being used. Every unassigned code is tried, which separates pass-through from a stray decode.

A long pseudo-random stream then runs back to back with all sixteen codes. It confirms the one-cycle latency and the flag values under continuous issue.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_ADD = 4'h1,
        OP_SUB = 4'h2,
        OP_AND = 4'h3,
        OP_OR  = 4'h4,
        OP_INV = 4'h5,
        OP_SHR = 4'h6,
        OP_SHL = 4'h7,
        OP_MUL = 4'h8,
        OP_DIV = 4'h9
    } alu_op_e;

endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    // Adder, bitwise and shift paths; unknown codes fall back to a_i.
    always_comb begin
        res_o = a_i;
        case (op_i)
            OP_ADD: res_o = a_i + b_i;
            OP_SUB: res_o = a_i - b_i;
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_INV: res_o = ~b_i;
            OP_SHR: res_o = {1'b0, a_i[DATA_W-1:1]};
            OP_SHL: res_o = {a_i[DATA_W-2:0], 1'b0};
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
    parameter int DATA_W = 16,
    parameter int PROD_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] mul_o,
    output logic [DATA_W-1:0] div_o
);

    logic [DATA_W-1:0] prod_lo;

    assign prod_lo = a_i * b_i;

    generate
        if (PROD_W < DATA_W) begin : g_trunc
            localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << PROD_W) - 1);
            assign mul_o = prod_lo & KEEP_MASK;
        end else begin : g_full
            assign mul_o = prod_lo;
        end
    endgenerate

    // Quotient only; a zero divisor saturates to all ones (R9).
    always_comb begin
        if (b_i == '0) begin
            div_o = '1;
        end else begin
            div_o = a_i / b_i;
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PROD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] result_o,
    output logic              sign_o,
    output logic              zero_o
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              sign;
        logic              zero;
    } alu_out_t;

    localparam alu_out_t RESET_VAL = '{res: '0, sign: 1'b0, zero: 1'b1};

    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] mul_res;
    logic [DATA_W-1:0] div_res;
    alu_out_t          out_d;
    alu_out_t          out_q;

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op_i),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .res_o (logic_res)
    );

    acc_alu_muldiv #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_muldiv (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .mul_o (mul_res),
        .div_o (div_res)
    );

    always_comb begin
        out_d = out_q;
        case (op_i)
            OP_MUL:  out_d.res = mul_res;
            OP_DIV:  out_d.res = div_res;
            default: out_d.res = logic_res;
        endcase
        out_d.sign = out_d.res[DATA_W-1];
        out_d.zero = (out_d.res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= RESET_VAL;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign sign_o   = out_q.sign;
    assign zero_o   = out_q.zero;

    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !sign_o && zero_o));

    a_r10_pass_through: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'h0 || op_i >= 4'hA) |=> result_o == $past(acc_i));

    a_r4_inverts_operand: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INV) |=> result_o == ~$past(opnd_i));

    a_r9_div_by_zero: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DIV && opnd_i == '0) |=> result_o == '1);

    a_r5_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SHR) |=> (!result_o[DATA_W-1] && !sign_o));

    a_r7_mul_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MUL && PROD_W < DATA_W) |=> (result_o >> PROD_W) == '0);

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    typedef struct packed {
        logic [15:0] res;
        logic        sign;
        logic        zero;
        logic [3:0]  op;
        logic        dz;
        logic [15:0] a;
        logic [15:0] b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = 4'h1;
    logic [15:0] acc_i = 16'h0001;
    logic [15:0] opnd_i = 16'h0001;
    logic [15:0] result_o;
    logic        sign_o;
    logic        zero_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .result_o (result_o),
        .sign_o   (sign_o),
        .zero_o   (zero_o)
    );

    function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        case (op)
            4'h1: return a + b;
            4'h2: return a - b;
            4'h3: return a & b;
            4'h4: return a | b;
            4'h5: return ~b;
            4'h6: return a >> 1;
            4'h7: return a << 1;
            4'h8: begin
                p = {16'h0, a} * {16'h0, b};
                return {8'h00, p[7:0]};
            end
            4'h9: return (b == 16'h0) ? 16'hFFFF : a / b;
            default: return a;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic dz);
        case (op)
            4'h1: return "R1";
            4'h2: return "R2";
            4'h3: return "R3";
            4'h4: return "R3";
            4'h5: return "R4";
            4'h6: return "R5";
            4'h7: return "R6";
            4'h8: return "R7";
            4'h9: return dz ? "R9" : "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        exp_t e;
        @(negedge clk);
        op_i = op;
        acc_i = a;
        opnd_i = b;
        e.res = model(op, a, b);
        e.sign = e.res[15];
        e.zero = (e.res == 16'h0);
        e.op = op;
        e.dz = (op == 4'h9 && b == 16'h0);
        e.a = a;
        e.b = b;
        sb.push_back(e);
    endtask

    // Monitor: results appear one edge after the drive (R12).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (result_o !== e.res) begin
                    n_fail++;
                    $display("FAIL %s op=%h a=%h b=%h result got %h expected %h",
                             req_of(e.op, e.dz), e.op, e.a, e.b, result_o, e.res);
                end else if (sign_o !== e.sign || zero_o !== e.zero) begin
                    n_fail++;
                    $display("FAIL R11 op=%h a=%h b=%h flags got s%b z%b expected s%b z%b",
                             e.op, e.a, e.b, sign_o, zero_o, e.sign, e.zero);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R12: reset dominates an active add
        n_checks++;
        if (result_o !== 16'h0 || sign_o !== 1'b0 || zero_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R12 reset state got %h/s%b/z%b expected 0000/s0/z1", result_o, sign_o, zero_o);
        end
        rst = 1'b0;
        mon_on = 1'b1;
        // R1 wrap, zero and sign
        drive(4'h1, 16'hFFFF, 16'h0001);
        drive(4'h1, 16'h7FFF, 16'h0001);
        drive(4'h1, 16'h1234, 16'h4321);
        // R2
        drive(4'h2, 16'h0000, 16'h0001);
        drive(4'h2, 16'h0005, 16'h0005);
        drive(4'h2, 16'h8000, 16'h0001);
        // R3
        drive(4'h3, 16'hF0F0, 16'h3C3C);
        drive(4'h4, 16'hF0F0, 16'h0F0F);
        drive(4'h3, 16'hAAAA, 16'h5555);
        // R4 with differing accumulator
        drive(4'h5, 16'h1234, 16'h00FF);
        drive(4'h5, 16'hFFFF, 16'h00FF);
        drive(4'h5, 16'h0000, 16'hFFFF);
        // R5, R6
        drive(4'h6, 16'h8001, 16'h0000);
        drive(4'h6, 16'h0001, 16'hFFFF);
        drive(4'h7, 16'h8001, 16'h0000);
        drive(4'h7, 16'h4000, 16'hFFFF);
        // R7
        drive(4'h8, 16'd12, 16'd3);
        drive(4'h8, 16'h0100, 16'h0002);
        drive(4'h8, 16'h00FF, 16'h00FF);
        // R8, R9
        drive(4'h9, 16'd12, 16'd3);
        drive(4'h9, 16'd7, 16'd2);
        drive(4'h9, 16'hFFFF, 16'h0100);
        drive(4'h9, 16'd5, 16'd0);
        drive(4'h9, 16'd0, 16'd0);
        // R10 every unassigned code
        drive(4'h0, 16'h8765, 16'h1111);
        for (int c = 10; c < 16; c++) begin
            drive(c[3:0], 16'h0000 + 16'(c * 16'h1357), 16'hFFFF);
        end
        // back-to-back pseudo-random stream (all codes, R11 flags)
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = (i % 5 == 0) ? {12'h0, lfsr[3:0]} : lfsr;
            drive(lfsr[7:4], a, b);
        end
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R12 scoreboard left %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule